// File: doc/BRIEF.md
# Predicated Element Step Iterator

This block holds the position of a vector loop as two counters: a 7-bit element index and a 2-bit sub-element index. Each step request moves the pair to its next position. A sub-vector length code gives the last valid sub-element index, and a vector length gives the element count. An ordering flag chooses which counter is the inner loop. With the flag clear, the sub-element index runs fastest. With the flag set, the element index runs fastest and the sub-element index only moves when the element index wraps.

When skipping is enabled, a predicate mask lets the element index jump past masked-out positions in a single step. The next position is found by one combinational priority scan, so every step completes in one cycle. A sticky loop-end flag records that the walk has run past its final position, and it stays set until it is cleared.

One instance tracks the source side, with its ordering flag and source mask. A second instance tracks the destination side, with its own flag and mask.

Top module: `stepIter`

## Requirements
- R1: After reset, elemStep is 0, subStep is 0 and loopEnd is 0.
- R2: A cycle without stepReq leaves elemStep and subStep unchanged.
- R3: With packMode=1 and elemStep != vecLen-1, a step advances elemStep and leaves subStep unchanged.
- R4: With packMode=1, elemStep == vecLen-1 and subStep != subLen, a step increments subStep and sets elemStep to 0. The mask is not consulted for that 0.
- R5: With packMode=1, elemStep == vecLen-1 and subStep == subLen, a step sets loopEnd and leaves both counters unchanged.
- R6: With packMode=0 and subStep != subLen, a step increments subStep and leaves elemStep unchanged.
- R7: With packMode=0 and subStep == subLen, a step sets subStep to 0. It then does one of two things: it advances elemStep, or, if elemStep was vecLen-1, it sets elemStep to 0 and sets loopEnd.
- R8: With skipEn=1, advancing moves elemStep to the lowest index i above it, with i <= vecLen-1, whose predMask bit i is 1. Bit i of predMask belongs to element i. If there is no such index, elemStep moves to vecLen-1.
- R9: With skipEn=0, advancing adds exactly one to elemStep, whatever predMask holds.
- R10: loopEnd is sticky. clearEnd clears it at the next edge. When a step sets loopEnd in the same cycle as clearEnd, the set wins.
- R11: Every counter and flag update appears at the outputs on the clock edge that samples the request. vecLen is valid from 1 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepReq | input | 1 | Advance the position by one step this cycle |
| clearEnd | input | 1 | Clear the sticky loop-end flag |
| packMode | input | 1 | 1: element index is the inner loop; 0: sub-element index is the inner loop |
| skipEn | input | 1 | Skip positions whose predicate bit is 0 |
| vecLen | input | 7 | Vector length (1 to 127) |
| subLen | input | 2 | Last valid sub-element index |
| predMask | input | 128 | Predicate, bit i for element i |
| elemStep | output | 7 | Current element index |
| subStep | output | 2 | Current sub-element index |
| loopEnd | output | 1 | Sticky flag: the walk ran past its last position |

## Verification
A step that reaches the final position sets loopEnd, and clearEnd clears it. These two actions can fall in the same cycle. The bench provokes this by issuing a request with clearEnd high while both counters sit at their end positions in pack order, and it expects loopEnd to read 1 afterwards. A following clear with no request must bring it back to 0. The bench also steps toward a wrap with clearEnd high and expects the clear to take effect, because no set competes with it there.

// File: rtl/stepIterPkg.sv
package stepIterPkg;
  // Strobes from the control decision to the counter datapath
  typedef struct packed {
    logic advElem;   // move element index to its next position
    logic zeroElem;  // force element index to 0
    logic incSub;    // increment sub-element index
    logic clrSub;    // force sub-element index to 0
    logic setEnd;    // raise the sticky loop-end flag
  } stepCmd_t;
endpackage

// File: rtl/maskScan.sv
module maskScan #(
  parameter int STEP_W = 7,
  localparam int ELEMS = 1 << STEP_W
) (
  input  logic [STEP_W-1:0] curIdx,
  input  logic [STEP_W-1:0] lastIdx,
  input  logic [ELEMS-1:0]  mask,
  output logic [STEP_W-1:0] hitIdx
);
  // Lowest set mask bit strictly above curIdx and not beyond lastIdx;
  // falls back to lastIdx when none qualifies.
  always_comb begin
    hitIdx = lastIdx;
    for (int i = ELEMS - 1; i >= 0; i--) begin
      if (mask[i] && (i > int'(curIdx)) && (i <= int'(lastIdx)))
        hitIdx = STEP_W'(i);
    end
  end
endmodule

// File: rtl/stepIterCtrl.sv
module stepIterCtrl
  import stepIterPkg::*;
(
  input  logic     stepReq,
  input  logic     packMode,
  input  logic     elemAtEnd,
  input  logic     subAtEnd,
  output stepCmd_t cmd
);
  always_comb begin
    cmd = '0;
    if (stepReq) begin
      if (packMode) begin
        // element index is the inner loop
        if (!elemAtEnd) begin
          cmd.advElem = 1'b1;
        end else if (subAtEnd) begin
          cmd.setEnd = 1'b1;
        end else begin
          cmd.incSub   = 1'b1;
          cmd.zeroElem = 1'b1;
        end
      end else begin
        // sub-element index is the inner loop
        if (!subAtEnd) begin
          cmd.incSub = 1'b1;
        end else begin
          cmd.clrSub = 1'b1;
          if (elemAtEnd) begin
            cmd.zeroElem = 1'b1;
            cmd.setEnd   = 1'b1;
          end else begin
            cmd.advElem = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/stepIterDp.sv
module stepIterDp
  import stepIterPkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  localparam int ELEMS = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stepCmd_t          cmd,
  input  logic              clearEnd,
  input  logic              skipEn,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subLen,
  input  logic [ELEMS-1:0]  predMask,
  output logic [STEP_W-1:0] elemStep,
  output logic [SUB_W-1:0]  subStep,
  output logic              loopEnd,
  output logic              elemAtEnd,
  output logic              subAtEnd
);
  logic [STEP_W-1:0] lastIdx;
  logic [STEP_W-1:0] scanIdx;
  logic [STEP_W-1:0] nextElem;

  assign lastIdx   = vecLen - STEP_W'(1);
  assign elemAtEnd = (elemStep == lastIdx);
  assign subAtEnd  = (subStep == subLen);

  maskScan #(.STEP_W(STEP_W)) scanner (
    .curIdx (elemStep),
    .lastIdx(lastIdx),
    .mask   (predMask),
    .hitIdx (scanIdx)
  );

  assign nextElem = skipEn ? scanIdx : (elemStep + STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elemStep <= '0;
    end else if (cmd.zeroElem) begin
      elemStep <= '0;
    end else if (cmd.advElem) begin
      elemStep <= nextElem;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      subStep <= '0;
    end else if (cmd.clrSub) begin
      subStep <= '0;
    end else if (cmd.incSub) begin
      subStep <= subStep + SUB_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loopEnd <= 1'b0;
    end else if (cmd.setEnd) begin
      loopEnd <= 1'b1;
    end else if (clearEnd) begin
      loopEnd <= 1'b0;
    end
  end
endmodule

// File: rtl/stepIter.sv
module stepIter
  import stepIterPkg::*;
#(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  localparam int ELEMS = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stepReq,
  input  logic              clearEnd,
  input  logic              packMode,
  input  logic              skipEn,
  input  logic [STEP_W-1:0] vecLen,
  input  logic [SUB_W-1:0]  subLen,
  input  logic [ELEMS-1:0]  predMask,
  output logic [STEP_W-1:0] elemStep,
  output logic [SUB_W-1:0]  subStep,
  output logic              loopEnd
);
  stepCmd_t cmd;
  logic     elemAtEnd;
  logic     subAtEnd;

  stepIterCtrl ctrl (
    .stepReq  (stepReq),
    .packMode (packMode),
    .elemAtEnd(elemAtEnd),
    .subAtEnd (subAtEnd),
    .cmd      (cmd)
  );

  stepIterDp #(.STEP_W(STEP_W), .SUB_W(SUB_W)) dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .clearEnd (clearEnd),
    .skipEn   (skipEn),
    .vecLen   (vecLen),
    .subLen   (subLen),
    .predMask (predMask),
    .elemStep (elemStep),
    .subStep  (subStep),
    .loopEnd  (loopEnd),
    .elemAtEnd(elemAtEnd),
    .subAtEnd (subAtEnd)
  );
endmodule

// File: rtl/stepIterChk.sv
module stepIterChk #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stepReq,
  input logic              clearEnd,
  input logic              packMode,
  input logic              skipEn,
  input logic [STEP_W-1:0] vecLen,
  input logic [SUB_W-1:0]  subLen,
  input logic [STEP_W-1:0] elemStep,
  input logic [SUB_W-1:0]  subStep,
  input logic              loopEnd
);
  // R2: idle cycles hold both counters
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stepReq |=> ($stable(elemStep) && $stable(subStep)));

  // R3: pack order, element not at end, sub index untouched
  a_r3_pack_sub_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stepReq && packMode && elemStep != vecLen - STEP_W'(1))
      |=> subStep == $past(subStep));

  // R5: pack order, both at end, counters frozen and flag raised
  a_r5_pack_final: assert property (@(posedge clk) disable iff (!rst_n)
    (stepReq && packMode && elemStep == vecLen - STEP_W'(1) && subStep == subLen)
      |=> (loopEnd && $stable(elemStep) && $stable(subStep)));

  // R6: inner sub index counts up, element index untouched
  a_r6_inner_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (stepReq && !packMode && subStep != subLen)
      |=> (subStep == $past(subStep) + SUB_W'(1) && elemStep == $past(elemStep)));

  // R9: without skipping, the element index moves by exactly one
  a_r9_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stepReq && !skipEn && packMode && elemStep != vecLen - STEP_W'(1))
      |=> elemStep == $past(elemStep) + STEP_W'(1));

  // R10: flag stays set unless cleared
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (loopEnd && !clearEnd) |=> loopEnd);

  // R10: a clear with no request drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clearEnd && !stepReq) |=> !loopEnd);
endmodule

bind stepIter stepIterChk #(.STEP_W(STEP_W), .SUB_W(SUB_W)) chk (.*);

// File: tb/stepIter_test.sv
module stepIter_test;
  localparam int CLK_PERIOD = 10;
  localparam int STEP_W = 7;
  localparam int SUB_W  = 2;
  localparam int ELEMS  = 1 << STEP_W;
  localparam int NVEC   = 18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              stepReq, clearEnd, packMode, skipEn;
  logic [STEP_W-1:0] vecLen;
  logic [SUB_W-1:0]  subLen;
  logic [ELEMS-1:0]  predMask;
  logic [STEP_W-1:0] elemStep;
  logic [SUB_W-1:0]  subStep;
  logic              loopEnd;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stepIter #(.STEP_W(STEP_W), .SUB_W(SUB_W)) uut (
    .clk(clk), .rst_n(rst_n), .stepReq(stepReq), .clearEnd(clearEnd),
    .packMode(packMode), .skipEn(skipEn), .vecLen(vecLen), .subLen(subLen),
    .predMask(predMask), .elemStep(elemStep), .subStep(subStep), .loopEnd(loopEnd)
  );

  // Entry: {req, clr, pack, skip, vl[7], sl[2], mask[16], expElem[7], expSub[2], expEnd}
  localparam logic [38:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,1'b0,7'd3,2'd1,16'h0000,7'd0,2'd1,1'b0}, // R6
    {1'b1,1'b0,1'b0,1'b0,7'd3,2'd1,16'h0000,7'd1,2'd0,1'b0}, // R7 advance
    {1'b1,1'b0,1'b0,1'b0,7'd3,2'd1,16'h0000,7'd1,2'd1,1'b0}, // R6
    {1'b1,1'b0,1'b0,1'b0,7'd3,2'd1,16'h0000,7'd2,2'd0,1'b0}, // R7
    {1'b1,1'b0,1'b0,1'b0,7'd3,2'd1,16'h0000,7'd2,2'd1,1'b0}, // R6
    {1'b1,1'b0,1'b0,1'b0,7'd3,2'd1,16'h0000,7'd0,2'd0,1'b1}, // R7 wrap
    {1'b1,1'b1,1'b0,1'b1,7'd8,2'd0,16'h0050,7'd4,2'd0,1'b0}, // R8 R10
    {1'b1,1'b0,1'b0,1'b1,7'd8,2'd0,16'h0050,7'd6,2'd0,1'b0}, // R8
    {1'b1,1'b0,1'b0,1'b1,7'd8,2'd0,16'h0050,7'd7,2'd0,1'b0}, // R8 none -> VL-1
    {1'b1,1'b0,1'b0,1'b1,7'd8,2'd0,16'h0050,7'd0,2'd0,1'b1}, // R7 wrap
    {1'b1,1'b1,1'b1,1'b0,7'd4,2'd1,16'h0008,7'd1,2'd0,1'b0}, // R9 R3
    {1'b1,1'b0,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd3,2'd0,1'b0}, // R8 R3
    {1'b1,1'b0,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd0,2'd1,1'b0}, // R4
    {1'b1,1'b0,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd3,2'd1,1'b0}, // R3
    {1'b1,1'b0,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd3,2'd1,1'b1}, // R5
    {1'b1,1'b0,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd3,2'd1,1'b1}, // R5 again
    {1'b0,1'b0,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd3,2'd1,1'b1}, // R2
    {1'b0,1'b1,1'b1,1'b1,7'd4,2'd1,16'h0008,7'd3,2'd1,1'b0}  // R10 clear alone
  };

  task automatic check(input string req, input logic [STEP_W-1:0] eE,
                       input logic [SUB_W-1:0] eS, input logic eEnd);
    compared++;
    if (elemStep !== eE || subStep !== eS || loopEnd !== eEnd) begin
      mismatched++;
      $display("FAIL %s: got elem=%0d sub=%0d end=%0d, expected elem=%0d sub=%0d end=%0d",
               req, elemStep, subStep, loopEnd, eE, eS, eEnd);
    end
  endtask

  // Drive at negedge, let one posedge sample, return at the next negedge (R11)
  task automatic cycle(input logic req, input logic clr);
    stepReq = req;
    clearEnd = clr;
    @(negedge clk);
    stepReq = 1'b0;
    clearEnd = 1'b0;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    stepReq = 1'b0; clearEnd = 1'b0; packMode = 1'b0; skipEn = 1'b0;
    vecLen = 7'd1; subLen = '0; predMask = '0;
    @(negedge clk);
    doReset();
    check("R1 reset", 7'd0, 2'd0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      packMode = VEC[i][36];
      skipEn   = VEC[i][35];
      vecLen   = VEC[i][34:28];
      subLen   = VEC[i][27:26];
      predMask = '0;
      predMask[15:0] = VEC[i][25:10];
      cycle(VEC[i][38], VEC[i][37]);
      check($sformatf("R11 table[%0d]", i), VEC[i][9:3], VEC[i][2:1], VEC[i][0]);
    end

    // R10: final step and clear in the same cycle, set wins
    cycle(1'b1, 1'b1);
    check("R10 set beats clear", 7'd3, 2'd1, 1'b1);
    cycle(1'b0, 1'b1);
    check("R10 clear", 7'd3, 2'd1, 1'b0);

    // R1: reset from a busy state
    cycle(1'b1, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 mid-run reset", 7'd0, 2'd0, 1'b0);

    // R8 with a long vector: single set bit far away, then run to VL-1
    packMode = 1'b0; skipEn = 1'b1; vecLen = 7'd127; subLen = 2'd0;
    predMask = '0;
    predMask[100] = 1'b1;
    cycle(1'b1, 1'b0);
    check("R8 far jump", 7'd100, 2'd0, 1'b0);
    cycle(1'b1, 1'b0);
    check("R8 no hit to VL-1", 7'd126, 2'd0, 1'b0);
    cycle(1'b1, 1'b0);
    check("R7 long wrap", 7'd0, 2'd0, 1'b1);

    finish();
  end
endmodule